// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block turns one high-level storage request into the ordered string of bus steps that a single NAND flash chip expects. It handles four operations: erasing a block, programming a page, reading a page, and an in-chip copy that reads a source page into the chip's page register, overwrites a chosen span of bytes in that register, and programs the result into a destination page. Toward the chip it drives an abstract byte bus with separate strobes for command, address, write-data and read cycles, and it watches a ready/busy line from the chip.

A request is presented for one cycle while the sequencer is idle, with an operation code, page row, destination row (copy only), start column and byte count. Write data is pulled from the caller one byte per `wr_take` cycle. Read data leaves on `rd_data`/`rd_valid`. Each array wait lasts at least a parameterised number of clocks and also until the chip reports ready. Erase, program and copy end with a status read whose bit 0 gives the fail flag on the one-cycle `done` pulse. A page holds 2112 bytes: four 512-byte sectors of data and 16 spare bytes per sector.

Top module: `nand_op_seq`

## Requirements
- R1: After reset the sequencer is idle: `busy`, `done`, `req_err`, `rd_valid` and all four chip strobes are 0.
- R2: A request in idle with an operation code of 4 to 7 pulses `req_err` for that cycle, is not accepted, produces no chip strobe, and leaves the sequencer idle. Codes are 0 erase, 1 program, 2 read, 3 copy.
- R3: Erase issues command 0x60, the row address bytes least significant first (two bytes for a 16-bit row), command 0xD0, waits, then command 0x70 and one status read.
- R4: Program issues command 0x80, two column bytes then two row bytes (each least significant first), `req_len` data bytes taken in order from `wr_data`, command 0x10, waits, then command 0x70 and one status read.
- R5: Read issues command 0x00, column then row bytes, command 0x30, waits, then makes `req_len` read cycles; each byte appears on `rd_data` with `rd_valid` one cycle after its read strobe, in order, and `done_fail` is 0.
- R6: Copy issues 0x00, column 0 with the source row, 0x35, waits, then 0x85, the request column with the destination row, `req_len` data bytes, 0x10, waits, then 0x70 and a status read; the destination then holds the source page with only that span replaced.
- R7: After any confirm command (0xD0, 0x10, 0x30, 0x35) no strobe occurs until the matching wait count has elapsed and `nf_ready` is high; no strobe ever occurs while `nf_ready` is low.
- R8: `done` is a one-cycle pulse ending every accepted request; `done_fail` equals bit 0 of the status byte read (1 means failure), so programming an already-written page reports failure.
- R9: A request presented while the sequencer is busy is not accepted and changes nothing on the chip bus.
- R10: A program or copy with `req_len` of 0 makes no data-write cycle and otherwise follows its normal order.
- R11: At most one of the four chip strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (0 erase, 1 program, 2 read, 3 copy) |
| req_row | input | ROW_W | Page row (source row for copy) |
| req_dst_row | input | ROW_W | Destination row for copy |
| req_col | input | COL_W | First column for data transfer |
| req_len | input | LEN_W | Number of data bytes |
| req_accept | output | 1 | Request taken this cycle |
| req_err | output | 1 | Request rejected for an illegal code |
| busy | output | 1 | Sequencer not idle |
| wr_data | input | 8 | Next write byte from the caller |
| wr_take | output | 1 | `wr_data` consumed this cycle |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | `rd_data` valid |
| done | output | 1 | Request finished (one cycle) |
| done_fail | output | 1 | Status reported failure, valid with `done` |
| nf_cmd_we | output | 1 | Command byte strobe |
| nf_addr_we | output | 1 | Address byte strobe |
| nf_din_we | output | 1 | Write-data byte strobe |
| nf_re | output | 1 | Read strobe, `nf_rdata` sampled at the clock edge |
| nf_wdata | output | 8 | Byte for command, address or data strobe |
| nf_rdata | input | 8 | Byte returned by the chip |
| nf_ready | input | 1 | Chip ready (low while array is busy) |

## Verification
A wrong state in this block shows first on the chip bus: a misrouted transition yields a missing, extra or reordered command, address or data strobe in the very cycle it happens, so every strobe is compared against an expected queue as it appears. A wait counter that runs short shows as a strobe arriving too soon after a confirm command, measured in cycles against the configured wait and the chip's busy time. A mishandled data count or column shows one request later, when a read of the written page returns the wrong bytes, and a dropped status bit shows on `done_fail` at the end of the same request.

// File: rtl/nand_seq_pkg.sv
// Shared types and command bytes for the NAND operation sequencer.
// Assumes a chip that uses the common two-cycle setup/confirm command pairs.
package nand_seq_pkg;

    typedef enum logic [2:0] {
        OP_ERASE = 3'd0,
        OP_PROG  = 3'd1,
        OP_READ  = 3'd2,
        OP_COPY  = 3'd3
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD1,
        ST_ADDR,
        ST_DIN,
        ST_CMD2,
        ST_WAIT,
        ST_DOUT,
        ST_SCMD,
        ST_SRD,
        ST_DONE
    } st_e;

    localparam logic [7:0] CMD_RD_SETUP = 8'h00;
    localparam logic [7:0] CMD_RD_GO    = 8'h30;
    localparam logic [7:0] CMD_CP_LOAD  = 8'h35;
    localparam logic [7:0] CMD_PG_SETUP = 8'h80;
    localparam logic [7:0] CMD_CP_SETUP = 8'h85;
    localparam logic [7:0] CMD_PG_GO    = 8'h10;
    localparam logic [7:0] CMD_ER_SETUP = 8'h60;
    localparam logic [7:0] CMD_ER_GO    = 8'hD0;
    localparam logic [7:0] CMD_STATUS   = 8'h70;

endpackage

// File: rtl/nand_wait_timer.sv
// Down-counter for array wait phases.
// Loaded on the confirm command, counts while the sequencer waits, holds at 0.
module nand_wait_timer #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    // Load, count down while running, saturate at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (run && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R7
    // timer_hold_chk: an idle, expired timer stays expired until reloaded
    timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);

endmodule

// File: rtl/nand_byte_count.sv
// Remaining-byte counter for the data-in and data-out phases.
// Assumes the owner never decrements once the count reaches zero.
module nand_byte_count #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    // Load on accept, decrement per transferred byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R10
    // cnt_no_wrap_chk: no byte is moved when none remain
    cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> !zero);

endmodule

// File: rtl/nand_addr_pick.sv
// Selects one address byte out of {row, column}, least significant first.
// Index 0..COL_BYTES-1 are column bytes, the rest are row bytes.
module nand_addr_pick #(
    parameter int COL_W = 12,
    parameter int ROW_W = 16,
    parameter int IDX_W = 3
) (
    input  logic [COL_W-1:0] col,
    input  logic [ROW_W-1:0] row,
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       abyte
);

    localparam int COL_BYTES = (COL_W + 7) / 8;
    localparam int ROW_BYTES = (ROW_W + 7) / 8;
    localparam int N_BYTES   = COL_BYTES + ROW_BYTES;

    logic [8*N_BYTES-1:0] vec;
    logic [7:0]           slice [N_BYTES];

    assign vec = {(8*ROW_BYTES)'(row), (8*COL_BYTES)'(col)};

    // One byte lane per address cycle.
    for (genvar g = 0; g < N_BYTES; g++) begin : g_lane
        assign slice[g] = vec[8*g +: 8];
    end

    // Pick the lane for the current address cycle.
    always_comb begin
        abyte = 8'h00;
        for (int k = 0; k < N_BYTES; k++)
            if (int'(idx) == k) abyte = slice[k];
    end

endmodule

// File: rtl/nand_op_seq.sv
// NAND operation sequencer: expands erase, program, read and copy requests
// into command/address/data/status steps on an abstract chip byte bus.
// Assumes req_len never exceeds the page size and the write source presents
// the next byte whenever wr_take is high.
module nand_op_seq
    import nand_seq_pkg::*;
#(
    parameter int ROW_W          = 16,
    parameter int COL_W          = 12,
    parameter int SECT_BYTES     = 512,
    parameter int SECTORS        = 4,
    parameter int SPARE_PER_SECT = 16,
    parameter int T_ERASE_CYC    = 100000,
    parameter int T_PROG_CYC     = 10000,
    parameter int T_READ_CYC     = 1000,
    localparam int PAGE_BYTES    = SECTORS * (SECT_BYTES + SPARE_PER_SECT),
    localparam int LEN_W         = $clog2(PAGE_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_op,
    input  logic [ROW_W-1:0] req_row,
    input  logic [ROW_W-1:0] req_dst_row,
    input  logic [COL_W-1:0] req_col,
    input  logic [LEN_W-1:0] req_len,
    output logic             req_accept,
    output logic             req_err,
    output logic             busy,
    input  logic [7:0]       wr_data,
    output logic             wr_take,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             done,
    output logic             done_fail,
    output logic             nf_cmd_we,
    output logic             nf_addr_we,
    output logic             nf_din_we,
    output logic             nf_re,
    output logic [7:0]       nf_wdata,
    input  logic [7:0]       nf_rdata,
    input  logic             nf_ready
);

    localparam int COL_BYTES  = (COL_W + 7) / 8;
    localparam int ROW_BYTES  = (ROW_W + 7) / 8;
    localparam int ADDR_BYTES = COL_BYTES + ROW_BYTES;
    localparam int IDX_W      = $clog2(ADDR_BYTES + 1);
    localparam int T_MAX12    = (T_ERASE_CYC > T_PROG_CYC) ? T_ERASE_CYC : T_PROG_CYC;
    localparam int T_MAX      = (T_MAX12 > T_READ_CYC) ? T_MAX12 : T_READ_CYC;
    localparam int TMR_W      = $clog2(T_MAX + 1);

    st_e              st_q, st_d;
    op_e              op_q;
    logic             cp2_q;
    logic [ROW_W-1:0] row_q, dst_q;
    logic [COL_W-1:0] col_q;
    logic             fail_q;
    logic [IDX_W-1:0] aidx_q;
    logic [7:0]       rd_data_q;
    logic             rd_valid_q;

    logic             tmr_zero, cnt_zero;
    logic             in_wait, addr_last, data_in_phase;
    logic [TMR_W-1:0] tmr_val;
    logic [7:0]       cmd1_byte, cmd2_byte, addr_byte;
    logic [COL_W-1:0] sel_col;
    logic [ROW_W-1:0] sel_row;
    logic             dout_go;

    assign req_accept = (st_q == ST_IDLE) && req_valid && !req_op[2];
    assign req_err    = (st_q == ST_IDLE) && req_valid &&  req_op[2];
    assign busy       = (st_q != ST_IDLE);
    assign done       = (st_q == ST_DONE);
    assign done_fail  = done && fail_q;
    assign in_wait    = (st_q == ST_WAIT);
    assign addr_last  = (aidx_q == IDX_W'(ADDR_BYTES - 1));
    assign data_in_phase = (op_q == OP_PROG) || (op_q == OP_COPY && cp2_q);
    assign dout_go    = (st_q == ST_DOUT) && !cnt_zero;

    // Setup and confirm command bytes for the current operation and phase.
    always_comb begin
        unique case (op_q)
            OP_ERASE: begin cmd1_byte = CMD_ER_SETUP; cmd2_byte = CMD_ER_GO; end
            OP_PROG:  begin cmd1_byte = CMD_PG_SETUP; cmd2_byte = CMD_PG_GO; end
            OP_READ:  begin cmd1_byte = CMD_RD_SETUP; cmd2_byte = CMD_RD_GO; end
            default:  begin
                cmd1_byte = cp2_q ? CMD_CP_SETUP : CMD_RD_SETUP;
                cmd2_byte = cp2_q ? CMD_PG_GO    : CMD_CP_LOAD;
            end
        endcase
    end

    // Wait length chosen by the array operation the confirm starts.
    always_comb begin
        unique case (op_q)
            OP_ERASE: tmr_val = TMR_W'(T_ERASE_CYC);
            OP_PROG:  tmr_val = TMR_W'(T_PROG_CYC);
            OP_READ:  tmr_val = TMR_W'(T_READ_CYC);
            default:  tmr_val = cp2_q ? TMR_W'(T_PROG_CYC) : TMR_W'(T_READ_CYC);
        endcase
    end

    // Address source: copy load phase reads from column 0 of the source row.
    always_comb begin
        sel_col = col_q;
        sel_row = row_q;
        if (op_q == OP_COPY) begin
            sel_col = cp2_q ? col_q : '0;
            sel_row = cp2_q ? dst_q : row_q;
        end
    end

    // Chip bus strobes and byte, decoded from the state.
    always_comb begin
        nf_cmd_we  = 1'b0;
        nf_addr_we = 1'b0;
        nf_din_we  = 1'b0;
        nf_re      = 1'b0;
        nf_wdata   = 8'h00;
        unique case (st_q)
            ST_CMD1: begin nf_cmd_we = 1'b1; nf_wdata = cmd1_byte; end
            ST_CMD2: begin nf_cmd_we = 1'b1; nf_wdata = cmd2_byte; end
            ST_SCMD: begin nf_cmd_we = 1'b1; nf_wdata = CMD_STATUS; end
            ST_ADDR: begin nf_addr_we = 1'b1; nf_wdata = addr_byte; end
            ST_DIN:  begin nf_din_we = !cnt_zero; nf_wdata = wr_data; end
            ST_DOUT: nf_re = !cnt_zero;
            ST_SRD:  nf_re = 1'b1;
            default: ;
        endcase
    end

    assign wr_take = nf_din_we;

    // Next-state decision of the operation sequence.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (req_accept) st_d = ST_CMD1;
            ST_CMD1: st_d = ST_ADDR;
            ST_ADDR: if (addr_last) st_d = data_in_phase ? ST_DIN : ST_CMD2;
            ST_DIN:  if (cnt_zero) st_d = ST_CMD2;
            ST_CMD2: st_d = ST_WAIT;
            ST_WAIT: if (tmr_zero && nf_ready) begin
                if (op_q == OP_READ)               st_d = ST_DOUT;
                else if (op_q == OP_COPY && !cp2_q) st_d = ST_CMD1;
                else                               st_d = ST_SCMD;
            end
            ST_DOUT: if (cnt_zero) st_d = ST_DONE;
            ST_SCMD: st_d = ST_SRD;
            ST_SRD:  st_d = ST_DONE;
            default: st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Latch the request fields on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= OP_ERASE;
            row_q <= '0;
            dst_q <= '0;
            col_q <= '0;
        end else if (req_accept) begin
            op_q  <= op_e'(req_op);
            row_q <= req_row;
            dst_q <= req_dst_row;
            col_q <= req_col;
        end
    end

    // Copy phase flag: set when the load phase wait completes.
    always_ff @(posedge clk) begin
        if (!rst_n || req_accept)
            cp2_q <= 1'b0;
        else if (in_wait && st_d == ST_CMD1)
            cp2_q <= 1'b1;
    end

    // Address byte index: erase starts past the column bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            aidx_q <= '0;
        else if (st_q == ST_CMD1)
            aidx_q <= (op_q == OP_ERASE) ? IDX_W'(COL_BYTES) : '0;
        else if (st_q == ST_ADDR)
            aidx_q <= aidx_q + 1'b1;
    end

    // Status capture: bit 0 of the status byte is the fail flag.
    always_ff @(posedge clk) begin
        if (!rst_n || req_accept)
            fail_q <= 1'b0;
        else if (st_q == ST_SRD)
            fail_q <= nf_rdata[0];
    end

    // Read data output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q  <= 8'h00;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= dout_go;
            if (dout_go) rd_data_q <= nf_rdata;
        end
    end

    assign rd_data  = rd_data_q;
    assign rd_valid = rd_valid_q;

    nand_wait_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (st_q == ST_CMD2),
        .load_val (tmr_val),
        .run      (in_wait),
        .zero     (tmr_zero)
    );

    nand_byte_count #(.W(LEN_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (req_accept),
        .load_val (req_len),
        .dec      (nf_din_we || dout_go),
        .zero     (cnt_zero)
    );

    nand_addr_pick #(.COL_W(COL_W), .ROW_W(ROW_W), .IDX_W(IDX_W)) u_addr (
        .col   (sel_col),
        .row   (sel_row),
        .idx   (aidx_q),
        .abyte (addr_byte)
    );

    // R11
    // strobe_onehot_chk: one bus action per cycle at most
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nf_cmd_we, nf_addr_we, nf_din_we, nf_re}));

    // R7
    // busy_quiet_chk: the chip bus stays quiet while the array is busy
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_ready |-> !(nf_cmd_we || nf_addr_we || nf_din_we || nf_re));

    // R7
    // wait_exit_chk: a wait ends only with the timer expired and the chip ready
    wait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_wait) |-> ($past(tmr_zero) && $past(nf_ready)));

    // R8
    // done_pulse_chk: completion lasts exactly one cycle
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    // reject_idle_chk: a rejected request leaves the sequencer idle
    reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |=> !busy);

    // R9
    // no_accept_busy_chk: nothing is taken while a sequence is in flight
    no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> !req_accept);

endmodule

// File: tb/nand_op_seq_tb_top.sv
// Scoreboard bench: tasks queue the expected chip-bus and read-data items,
// monitors pop and compare them; a behavioural chip stub answers the bus.
module nand_op_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ROW_W = 16;
    localparam int COL_W = 12;
    localparam int T_ER  = 20;
    localparam int T_PG  = 10;
    localparam int T_RD  = 6;
    localparam int PAGE  = 2112;
    localparam int LEN_W = $clog2(PAGE + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic             req_valid = 1'b0;
    logic [2:0]       req_op = '0;
    logic [ROW_W-1:0] req_row = '0, req_dst_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic req_accept, req_err, busy, wr_take, rd_valid, done, done_fail;
    logic [7:0] wr_data, rd_data, nf_wdata, nf_rdata;
    logic nf_cmd_we, nf_addr_we, nf_din_we, nf_re, nf_ready;

    nand_op_seq #(
        .ROW_W(ROW_W), .COL_W(COL_W),
        .T_ERASE_CYC(T_ER), .T_PROG_CYC(T_PG), .T_READ_CYC(T_RD)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_row(req_row),
        .req_dst_row(req_dst_row), .req_col(req_col), .req_len(req_len),
        .req_accept(req_accept), .req_err(req_err), .busy(busy),
        .wr_data(wr_data), .wr_take(wr_take),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .done(done), .done_fail(done_fail),
        .nf_cmd_we(nf_cmd_we), .nf_addr_we(nf_addr_we), .nf_din_we(nf_din_we),
        .nf_re(nf_re), .nf_wdata(nf_wdata), .nf_rdata(nf_rdata), .nf_ready(nf_ready)
    );

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    string cur_tag = "R1";

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- write-data source ----------------
    logic [7:0] src [0:15];
    int wr_cnt = 0, wr_base = 0;
    always @(posedge clk) if (wr_take) wr_cnt <= wr_cnt + 1;
    assign wr_data = src[(wr_cnt - wr_base) & 15];

    // ---------------- chip stub ----------------
    logic [7:0] mem [int];
    logic [7:0] pbuf [0:PAGE-1];
    int   ptr = 0;
    int   busy_cnt = 0;
    int   stub_busy = 3;
    logic stat_mode = 1'b0;
    logic st_fail = 1'b0;
    int   arow = 0, acol = 0, aidx = 0;

    assign nf_ready = (busy_cnt == 0);
    assign nf_rdata = stat_mode ? {7'h70, st_fail} : pbuf[ptr];

    always @(posedge clk) begin
        if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
        if (nf_cmd_we) begin
            case (nf_wdata)
                8'h00, 8'h85: begin aidx = 0; arow = 0; acol = 0; stat_mode <= 1'b0; end
                8'h80: begin
                    aidx = 0; arow = 0; acol = 0; stat_mode <= 1'b0;
                    for (int k = 0; k < PAGE; k++) pbuf[k] <= 8'hFF;
                end
                8'h60: begin aidx = 2; arow = 0; stat_mode <= 1'b0; end
                8'h30, 8'h35: begin
                    for (int k = 0; k < PAGE; k++)
                        pbuf[k] <= mem.exists(arow*4096 + k) ? mem[arow*4096 + k] : 8'hFF;
                    ptr <= acol;
                    busy_cnt <= stub_busy;
                end
                8'h10: begin
                    logic bad;
                    bad = 1'b0;
                    for (int k = 0; k < PAGE; k++) if (mem.exists(arow*4096 + k)) bad = 1'b1;
                    if (!bad)
                        for (int k = 0; k < PAGE; k++)
                            if (pbuf[k] != 8'hFF) mem[arow*4096 + k] = pbuf[k];
                    st_fail <= bad;
                    busy_cnt <= stub_busy;
                end
                8'hD0: begin
                    int ks[$];
                    foreach (mem[key]) if (((key >> 12) >> 6) == (arow >> 6)) ks.push_back(key);
                    foreach (ks[i]) mem.delete(ks[i]);
                    st_fail <= 1'b0;
                    busy_cnt <= stub_busy;
                end
                8'h70: stat_mode <= 1'b1;
                default: ;
            endcase
        end
        if (nf_addr_we) begin
            if (aidx < 2) begin acol = acol | (int'(nf_wdata) << (8*aidx)); ptr <= acol; end
            else arow = arow | (int'(nf_wdata) << (8*(aidx-2)));
            aidx = aidx + 1;
        end
        if (nf_din_we) begin pbuf[ptr] <= nf_wdata; ptr <= ptr + 1; end
        if (nf_re && !stat_mode) ptr <= ptr + 1;
    end

    // ---------------- scoreboard ----------------
    // item = {kind[2:0], byte}; kind 1 cmd, 2 addr, 3 data-in, 4 read
    logic [10:0] bus_q[$];
    logic [7:0]  rd_q[$];
    int conf_cyc = -1, conf_min = 0, multi = 0;

    function automatic int maxi(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Bus monitor: compare each strobe with the next expected item.
    always @(negedge clk) begin
        if (rst_n) begin
            int kind;
            kind = 0;
            if ((nf_cmd_we + nf_addr_we + nf_din_we + nf_re) > 1) multi++;
            if (nf_cmd_we) kind = 1;
            else if (nf_addr_we) kind = 2;
            else if (nf_din_we) kind = 3;
            else if (nf_re) kind = 4;
            if (kind != 0) begin
                if (conf_cyc >= 0) begin
                    // R7 gap after a confirm command
                    check((cyc - conf_cyc) >= conf_min && (cyc - conf_cyc) <= conf_min + 2,
                          "R7", cyc - conf_cyc, conf_min);
                    conf_cyc = -1;
                end
                if (bus_q.size() == 0) begin
                    check(1'b0, cur_tag, {kind[2:0], nf_wdata}, 0);
                end else begin
                    logic [10:0] e;
                    e = bus_q.pop_front();
                    if (kind == 4) check(e[10:8] == 3'd4, cur_tag, kind, e[10:8]);
                    else check(e == {kind[2:0], nf_wdata}, cur_tag, {kind[2:0], nf_wdata}, e);
                end
                if (kind == 1 && (nf_wdata == 8'hD0 || nf_wdata == 8'h10 ||
                                  nf_wdata == 8'h30 || nf_wdata == 8'h35)) begin
                    int t;
                    t = (nf_wdata == 8'hD0) ? T_ER : (nf_wdata == 8'h10) ? T_PG : T_RD;
                    conf_cyc = cyc;
                    conf_min = maxi(t, stub_busy) + 1;
                end
            end
            if (rd_valid) begin
                if (rd_q.size() == 0) check(1'b0, "R5", rd_data, 0);
                else begin
                    logic [7:0] e8;
                    e8 = rd_q.pop_front();
                    check(rd_data == e8, "R5", rd_data, e8);
                end
            end
        end
    end

    // ---------------- driver helpers ----------------
    task automatic exp_cmd(input logic [7:0] b); bus_q.push_back({3'd1, b}); endtask
    task automatic exp_addr(input int col, input int row, input bit with_col);
        if (with_col) begin
            bus_q.push_back({3'd2, 8'(col)});
            bus_q.push_back({3'd2, 8'(col >> 8)});
        end
        bus_q.push_back({3'd2, 8'(row)});
        bus_q.push_back({3'd2, 8'(row >> 8)});
    endtask
    task automatic exp_din(input int n);
        for (int i = 0; i < n; i++) bus_q.push_back({3'd3, src[i]});
    endtask
    task automatic exp_re(input int n);
        for (int i = 0; i < n; i++) bus_q.push_back({3'd4, 8'h00});
    endtask

    task automatic launch(input int op, input int row, input int dst, input int col, input int len);
        @(negedge clk);
        wr_base = wr_cnt;
        req_op = 3'(op); req_row = ROW_W'(row); req_dst_row = ROW_W'(dst);
        req_col = COL_W'(col); req_len = LEN_W'(len); req_valid = 1'b1;
        #1;
        check(req_accept == 1'b1 && req_err == 1'b0, cur_tag, req_accept, 1);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_req(input bit exp_fail);
        int n;
        n = 0;
        while (!done && n < 3000) begin @(negedge clk); n++; end
        check(done == 1'b1, "R8", done, 1);
        check(done_fail == exp_fail, "R8", done_fail, exp_fail);
        @(negedge clk);
        #1;
        check(done == 1'b0 && busy == 1'b0, "R8", {done, busy}, 0);
        check(bus_q.size() == 0, cur_tag, bus_q.size(), 0);
        check(rd_q.size() == 0, cur_tag, rd_q.size(), 0);
    endtask

    task automatic do_erase(input int row);
        exp_cmd(8'h60); exp_addr(0, row, 0); exp_cmd(8'hD0); exp_cmd(8'h70); exp_re(1);
        launch(0, row, 0, 0, 0);
    endtask
    task automatic do_prog(input int row, input int col, input int len);
        exp_cmd(8'h80); exp_addr(col, row, 1); exp_din(len); exp_cmd(8'h10);
        exp_cmd(8'h70); exp_re(1);
        launch(1, row, 0, col, len);
    endtask
    task automatic do_read(input int row, input int col, input int len);
        exp_cmd(8'h00); exp_addr(col, row, 1); exp_cmd(8'h30); exp_re(len);
        launch(2, row, 0, col, len);
    endtask
    task automatic do_copy(input int s, input int d, input int col, input int len);
        exp_cmd(8'h00); exp_addr(0, s, 1); exp_cmd(8'h35);
        exp_cmd(8'h85); exp_addr(col, d, 1); exp_din(len); exp_cmd(8'h10);
        exp_cmd(8'h70); exp_re(1);
        launch(3, s, d, col, len);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // ---------------- test sequence ----------------
    initial begin
        for (int i = 0; i < 16; i++) src[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        check({busy, done, req_err, rd_valid} == 4'b0, "R1", {busy, done, req_err, rd_valid}, 0);
        check({nf_cmd_we, nf_addr_we, nf_din_we, nf_re} == 4'b0, "R1",
              {nf_cmd_we, nf_addr_we, nf_din_we, nf_re}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R1", busy, 0);

        // R2 illegal operation code
        cur_tag = "R2";
        req_op = 3'd5; req_valid = 1'b1;
        #1;
        check(req_err == 1'b1 && req_accept == 1'b0, "R2", {req_err, req_accept}, 2'b10);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check(req_err == 1'b0 && busy == 1'b0, "R2", {req_err, busy}, 0);
        repeat (3) @(negedge clk);
        check(bus_q.size() == 0 && busy == 1'b0, "R2", busy, 0);

        // R3 erase block containing rows 0x40..0x7F
        cur_tag = "R3";
        do_erase(16'h0041);
        finish_req(1'b0);

        // R4 program row 0x41, column 0, eight bytes
        cur_tag = "R4";
        for (int i = 0; i < 8; i++) src[i] = 8'hA0 + 8'(i);
        do_prog(16'h0041, 0, 8);
        finish_req(1'b0);

        // R5 read back four bytes from column 2
        cur_tag = "R5";
        for (int i = 2; i < 6; i++) rd_q.push_back(8'hA0 + 8'(i));
        do_read(16'h0041, 2, 4);
        finish_req(1'b0);

        // R8 program of an already written page reports failure
        cur_tag = "R8";
        do_prog(16'h0041, 0, 8);
        finish_req(1'b1);

        // R6 copy 0x41 -> 0x42 replacing columns 4..6
        cur_tag = "R6";
        src[0] = 8'hC0; src[1] = 8'hC1; src[2] = 8'hC2;
        do_copy(16'h0041, 16'h0042, 4, 3);
        finish_req(1'b0);
        cur_tag = "R6";
        rd_q.push_back(8'hA0); rd_q.push_back(8'hA1); rd_q.push_back(8'hA2);
        rd_q.push_back(8'hA3); rd_q.push_back(8'hC0); rd_q.push_back(8'hC1);
        rd_q.push_back(8'hC2); rd_q.push_back(8'hA7);
        exp_cmd(8'h00); exp_addr(0, 16'h0042, 1); exp_cmd(8'h30); exp_re(8);
        launch(2, 16'h0042, 0, 0, 8);
        finish_req(1'b0);

        // R10 program with zero length: no data cycles
        cur_tag = "R10";
        do_prog(16'h0043, 0, 0);
        finish_req(1'b0);

        // R9 request while busy is ignored
        cur_tag = "R9";
        src[0] = 8'h5A; src[1] = 8'h3C;
        do_prog(16'h0044, 0, 2);
        repeat (6) @(negedge clk);
        req_op = 3'd0; req_row = 16'h0044; req_valid = 1'b1;
        #1;
        check(req_accept == 1'b0 && busy == 1'b1, "R9", req_accept, 0);
        @(negedge clk);
        req_valid = 1'b0;
        finish_req(1'b0);
        repeat (4) @(negedge clk);
        check(busy == 1'b0 && bus_q.size() == 0, "R9", busy, 0);

        // R7 chip busy longer than the programmed wait
        cur_tag = "R7";
        stub_busy = 40;
        src[0] = 8'h11;
        do_prog(16'h0045, 0, 1);
        finish_req(1'b0);
        stub_busy = 3;

        // R11 never more than one strobe in a cycle
        check(multi == 0, "R11", multi, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule